// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the decision core of an on-chip debug trigger. Three address comparators deliver single-cycle match strobes on channels M0, M1 and M2. The sequencer walks a three-state graph (State1, State2, Final) and raises a one-cycle trigger pulse when it enters Final. Two 3-bit selector fields choose the pattern: one governs the exits from State1 and the other the exits from State2. The supported patterns are:

- a single event from any enabled channel;
- an ordered pair of events;
- a pair in which either event is entry into an address range;
- an order-check mode that fires when two events fail to alternate.

In range mode the comparators behind M0 and M1 act together as one range detector. The M0 strobe then signals range entry, and the M1 strobe is ignored. Software programs the selectors and the range enable, then raises `arm_i`. Dropping `arm_i` returns the machine to State1, which is also how a finished trigger is re-armed.

States and transitions:

- **State1 (code 0):**
  - *advance*: the selected event moves the machine to State2.
  - *jump*: any enabled event goes directly to Final.
  - *alt-start*: in order-check mode, an A or B event moves the machine to State2 and records which one it was.
- **State2 (code 1):**
  - *complete*: the selected event moves the machine to Final.
  - *alt-swap*: the event other than the recorded one stays in State2 and updates the record.
  - *alt-repeat*: the same event as the recorded one moves the machine to Final.
- **Final (code 2):** held while armed.
- **disarm:** from any state, the machine returns to State1.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset, and during an asynchronous reset (`rst_ni` low), `state_o` is 0 (State1) and `trig_o` is 0. State codes are 0 = State1, 1 = State2, 2 = Final, and the value 3 never appears.
- R2: While `arm_i` is low, the next clock edge puts the machine in State1, whatever the match strobes or selectors are.
- R3: Selector codes are 1 = M0, 2 = M1, 3 = M2 (`match_i` bits 0, 1 and 2). In State1 a strobe on the channel chosen by `sel_s1_i` moves the machine to State2. In State2 a strobe on the channel chosen by `sel_s2_i` moves it to Final. Strobes on other channels have no effect.
- R4: Selector code 4 (range) responds to `match_i[0]` only while `range_en_i` is 1, and may be used as either the first or the second event. With `range_en_i` at 0, code 4 never causes a transition.
- R5: While `range_en_i` is 1, a strobe on `match_i[1]` causes no transition under any selector code.
- R6: Selector code 5 in `sel_s1_i` sends State1 directly to Final on a strobe from any enabled channel. Only code 5 can reach Final from State1 in one step.
- R7: Selector code 6 is order-check mode, with event A = `match_i[0]` and event B = `match_i[2]`. In State1 either event moves the machine to State2 and is recorded. In State2, the event other than the recorded one updates the record and the machine stays. The same event again enters Final.
- R8: In order-check mode, A and B strobing in the same cycle count as A only (priority M0 over M1 over M2).
- R9: `trig_o` is high for exactly the one cycle that follows the edge on which Final is entered.
- R10: Final is held while `arm_i` stays high, with no further trigger pulse.
- R11: Selector codes 0 and 7 disable the transition out of their state.
- R12: The machine takes at most one transition per clock edge. For example, with code 1 in both selectors, a single M0 strobe only reaches State2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm level; low holds State1 |
| range_en_i | input | 1 | Comparators behind M0/M1 act as one range detector |
| match_i | input | 3 | Match strobes, bit n = channel Mn |
| sel_s1_i | input | 3 | Transition selector for State1 |
| sel_s2_i | input | 3 | Transition selector for State2 |
| state_o | output | 2 | Current state code |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The bound checker watches several invariants every cycle:

- the state code stays legal;
- the disarm return to State1 happens;
- the trigger is a single pulse that coincides with Final entry;
- Final is held while armed;
- M1 is masked in range mode;
- the disabled selector codes never move the machine;
- State1 reaches Final in one step only under the any-event code.

Some behaviour needs a history of strobes and can only be shown by the bench's vector scenarios. This covers the ordered pairs with range entry in either position, the order-check record and its alternation, and same-cycle priority between A and B. The bench also shows the single-step limit with identical selectors and asynchronous reset in the middle of a sequence.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

    localparam int NCH   = 3;
    localparam int SEL_W = 3;
    localparam int ST_W  = 2;
    localparam int NFLD  = 2;

    typedef enum logic [ST_W-1:0] {
        ST_ONE   = 2'd0,
        ST_TWO   = 2'd1,
        ST_FINAL = 2'd2
    } seq_state_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_OFF = 3'd0,
        SEL_M0  = 3'd1,
        SEL_M1  = 3'd2,
        SEL_M2  = 3'd3,
        SEL_RNG = 3'd4,
        SEL_ANY = 3'd5,
        SEL_ALT = 3'd6,
        SEL_RSV = 3'd7
    } sel_e;

    typedef enum logic [1:0] {
        LAST_NONE = 2'd0,
        LAST_A    = 2'd1,
        LAST_B    = 2'd2
    } last_e;

    // Qualified events after range-mode masking
    typedef struct packed {
        logic a;    // M0 strobe
        logic m1;   // M1 strobe, masked in range mode
        logic b;    // M2 strobe
        logic rng;  // range entry (M0 with range mode on)
        logic any;  // any enabled channel
    } ev_t;

endpackage

// File: rtl/dbg_seq_qual.sv
module dbg_seq_qual
    import dbg_seq_pkg::*;
(
    input  logic [NCH-1:0] match_i,
    input  logic           range_en_i,
    output ev_t            ev_o
);

    logic m1_q;

    always_comb begin
        m1_q      = match_i[1] & ~range_en_i;
        ev_o.a    = match_i[0];
        ev_o.m1   = m1_q;
        ev_o.b    = match_i[2];
        ev_o.rng  = match_i[0] & range_en_i;
        ev_o.any  = match_i[0] | m1_q | match_i[2];
    end

endmodule

// File: rtl/dbg_seq_fdec.sv
module dbg_seq_fdec
    import dbg_seq_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  ev_t              ev_i,
    output logic             hit_o,   // selected single event seen
    output logic             jump_o,  // any-event code fired
    output last_e            alt_o    // order-check event, A before B
);

    sel_e sel;

    always_comb begin
        sel    = sel_e'(sel_i);
        hit_o  = 1'b0;
        jump_o = 1'b0;
        alt_o  = LAST_NONE;
        unique case (sel)
            SEL_M0:  hit_o  = ev_i.a;
            SEL_M1:  hit_o  = ev_i.m1;
            SEL_M2:  hit_o  = ev_i.b;
            SEL_RNG: hit_o  = ev_i.rng;
            SEL_ANY: jump_o = ev_i.any;
            SEL_ALT: begin
                if (ev_i.a) begin
                    alt_o = LAST_A;
                end else if (ev_i.b) begin
                    alt_o = LAST_B;
                end
            end
            SEL_OFF, SEL_RSV: begin
                hit_o  = 1'b0;
                jump_o = 1'b0;
            end
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
    import dbg_seq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arm_i,
    input  logic             range_en_i,
    input  logic [NCH-1:0]   match_i,
    input  logic [SEL_W-1:0] sel_s1_i,
    input  logic [SEL_W-1:0] sel_s2_i,
    output logic [ST_W-1:0]  state_o,
    output logic             trig_o
);

    seq_state_e state_q, state_d;
    last_e      last_q, last_d;
    logic       trig_q;
    ev_t        ev;

    logic [SEL_W-1:0] sel_arr [NFLD];
    logic             hit  [NFLD];
    logic             jump [NFLD];
    last_e            alt  [NFLD];

    assign sel_arr[0] = sel_s1_i;
    assign sel_arr[1] = sel_s2_i;

    dbg_seq_qual u_qual (
        .match_i    (match_i),
        .range_en_i (range_en_i),
        .ev_o       (ev)
    );

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        dbg_seq_fdec u_fdec (
            .sel_i  (sel_arr[g]),
            .ev_i   (ev),
            .hit_o  (hit[g]),
            .jump_o (jump[g]),
            .alt_o  (alt[g])
        );
    end

    // Next-state graph
    always_comb begin
        state_d = state_q;
        last_d  = last_q;
        if (!arm_i) begin
            state_d = ST_ONE;
            last_d  = LAST_NONE;
        end else begin
            unique case (state_q)
                ST_ONE: begin
                    if (jump[0]) begin
                        state_d = ST_FINAL;
                    end else if (hit[0]) begin
                        state_d = ST_TWO;
                    end else if (alt[0] != LAST_NONE) begin
                        state_d = ST_TWO;
                        last_d  = alt[0];
                    end
                end
                ST_TWO: begin
                    if (jump[1] || hit[1]) begin
                        state_d = ST_FINAL;
                    end else if (alt[1] != LAST_NONE) begin
                        if (alt[1] == last_q) begin
                            state_d = ST_FINAL;
                        end else begin
                            last_d = alt[1];
                        end
                    end
                end
                ST_FINAL: state_d = ST_FINAL;
                default:  state_d = ST_ONE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_ONE;
            last_q  <= LAST_NONE;
        end else begin
            state_q <= state_d;
            last_q  <= last_d;
        end
    end

    // Output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= (state_d == ST_FINAL) && (state_q != ST_FINAL);
        end
    end

    assign state_o = state_q;
    assign trig_o  = trig_q;

endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk
    import dbg_seq_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             arm_i,
    input logic             range_en_i,
    input logic [NCH-1:0]   match_i,
    input logic [SEL_W-1:0] sel_s1_i,
    input logic [SEL_W-1:0] sel_s2_i,
    input logic [ST_W-1:0]  state_o,
    input logic             trig_o
);

    assert_state_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o != 2'd3);

    assert_disarm_home_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> (state_o == ST_ONE) && !trig_o);

    assert_m1_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i && range_en_i && state_o == ST_ONE && match_i == 3'b010
        |=> state_o == ST_ONE);

    assert_only_any_jumps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i && state_o == ST_ONE && sel_s1_i != SEL_ANY |=> state_o != ST_FINAL);

    assert_trig_on_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |-> (state_o == ST_FINAL) && ($past(state_o) != ST_FINAL));

    assert_trig_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |=> !trig_o);

    assert_final_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i && state_o == ST_FINAL |=> state_o == ST_FINAL);

    assert_off_codes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i && state_o == ST_ONE && (sel_s1_i == SEL_OFF || sel_s1_i == SEL_RSV)
        |=> state_o == ST_ONE);

endmodule

bind dbg_seq_top dbg_seq_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .range_en_i (range_en_i),
    .match_i    (match_i),
    .sel_s1_i   (sel_s1_i),
    .sel_s2_i   (sel_s2_i),
    .state_o    (state_o),
    .trig_o     (trig_o)
);

// File: tb/dbg_seq_top_tb.sv
module dbg_seq_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm = 1'b0;
    logic       ren = 1'b0;
    logic [2:0] mt = 3'b000;
    logic [2:0] s1 = 3'd0;
    logic [2:0] s2 = 3'd0;
    logic [1:0] st;
    logic       trg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dbg_seq_top u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .arm_i      (arm),
        .range_en_i (ren),
        .match_i    (mt),
        .sel_s1_i   (s1),
        .sel_s2_i   (s2),
        .state_o    (st),
        .trig_o     (trg)
    );

    // Layout: req[17:14] arm[13] ren[12] s1[11:9] s2[8:6] match{m2,m1,m0}[5:3] state[2:1] trig[0]
    localparam int NV = 45;
    localparam logic [17:0] VEC [NV] = '{
        // R3 ordered pair M0 then M2, R9 pulse, R10 hold, R2 disarm
        {4'd2,  1'b0, 1'b0, 3'd1, 3'd3, 3'b000, 2'd0, 1'b0},
        {4'd3,  1'b1, 1'b0, 3'd1, 3'd3, 3'b000, 2'd0, 1'b0},
        {4'd3,  1'b1, 1'b0, 3'd1, 3'd3, 3'b100, 2'd0, 1'b0},
        {4'd3,  1'b1, 1'b0, 3'd1, 3'd3, 3'b001, 2'd1, 1'b0},
        {4'd3,  1'b1, 1'b0, 3'd1, 3'd3, 3'b001, 2'd1, 1'b0},
        {4'd9,  1'b1, 1'b0, 3'd1, 3'd3, 3'b100, 2'd2, 1'b1},
        {4'd9,  1'b1, 1'b0, 3'd1, 3'd3, 3'b000, 2'd2, 1'b0},
        {4'd10, 1'b1, 1'b0, 3'd1, 3'd3, 3'b001, 2'd2, 1'b0},
        {4'd2,  1'b0, 1'b0, 3'd1, 3'd3, 3'b001, 2'd0, 1'b0},
        // R4 range entry first
        {4'd5,  1'b1, 1'b1, 3'd4, 3'd3, 3'b010, 2'd0, 1'b0},
        {4'd4,  1'b1, 1'b1, 3'd4, 3'd3, 3'b001, 2'd1, 1'b0},
        {4'd4,  1'b1, 1'b1, 3'd4, 3'd3, 3'b100, 2'd2, 1'b1},
        {4'd2,  1'b0, 1'b1, 3'd4, 3'd3, 3'b000, 2'd0, 1'b0},
        // R4 range entry second
        {4'd4,  1'b1, 1'b1, 3'd3, 3'd4, 3'b100, 2'd1, 1'b0},
        {4'd5,  1'b1, 1'b1, 3'd3, 3'd4, 3'b010, 2'd1, 1'b0},
        {4'd4,  1'b1, 1'b1, 3'd3, 3'd4, 3'b001, 2'd2, 1'b1},
        {4'd2,  1'b0, 1'b1, 3'd3, 3'd4, 3'b000, 2'd0, 1'b0},
        // R5 M1 masked in range mode, live otherwise
        {4'd5,  1'b1, 1'b1, 3'd2, 3'd2, 3'b010, 2'd0, 1'b0},
        {4'd3,  1'b1, 1'b0, 3'd2, 3'd2, 3'b010, 2'd1, 1'b0},
        {4'd3,  1'b1, 1'b0, 3'd2, 3'd2, 3'b010, 2'd2, 1'b1},
        {4'd2,  1'b0, 1'b0, 3'd2, 3'd2, 3'b000, 2'd0, 1'b0},
        // R6 any-event
        {4'd6,  1'b1, 1'b0, 3'd5, 3'd0, 3'b010, 2'd2, 1'b1},
        {4'd2,  1'b0, 1'b0, 3'd5, 3'd0, 3'b000, 2'd0, 1'b0},
        {4'd5,  1'b1, 1'b1, 3'd5, 3'd0, 3'b010, 2'd0, 1'b0},
        {4'd6,  1'b1, 1'b1, 3'd5, 3'd0, 3'b100, 2'd2, 1'b1},
        {4'd2,  1'b0, 1'b1, 3'd5, 3'd0, 3'b000, 2'd0, 1'b0},
        // R7 order check, R8 priority
        {4'd7,  1'b1, 1'b0, 3'd6, 3'd6, 3'b001, 2'd1, 1'b0},
        {4'd7,  1'b1, 1'b0, 3'd6, 3'd6, 3'b100, 2'd1, 1'b0},
        {4'd7,  1'b1, 1'b0, 3'd6, 3'd6, 3'b001, 2'd1, 1'b0},
        {4'd8,  1'b1, 1'b0, 3'd6, 3'd6, 3'b101, 2'd2, 1'b1},
        {4'd2,  1'b0, 1'b0, 3'd6, 3'd6, 3'b000, 2'd0, 1'b0},
        {4'd7,  1'b1, 1'b0, 3'd6, 3'd6, 3'b100, 2'd1, 1'b0},
        {4'd7,  1'b1, 1'b0, 3'd6, 3'd6, 3'b100, 2'd2, 1'b1},
        {4'd2,  1'b0, 1'b0, 3'd6, 3'd6, 3'b000, 2'd0, 1'b0},
        // R11 disabled codes
        {4'd11, 1'b1, 1'b0, 3'd0, 3'd0, 3'b111, 2'd0, 1'b0},
        {4'd11, 1'b1, 1'b0, 3'd7, 3'd0, 3'b111, 2'd0, 1'b0},
        {4'd2,  1'b0, 1'b0, 3'd7, 3'd0, 3'b000, 2'd0, 1'b0},
        // R4 range code dead without range mode
        {4'd4,  1'b1, 1'b0, 3'd4, 3'd3, 3'b001, 2'd0, 1'b0},
        {4'd2,  1'b0, 1'b0, 3'd4, 3'd3, 3'b000, 2'd0, 1'b0},
        // R12 one transition per edge
        {4'd12, 1'b1, 1'b0, 3'd1, 3'd1, 3'b001, 2'd1, 1'b0},
        {4'd12, 1'b1, 1'b0, 3'd1, 3'd1, 3'b001, 2'd2, 1'b1},
        {4'd2,  1'b0, 1'b0, 3'd1, 3'd1, 3'b000, 2'd0, 1'b0},
        // R11 disabled code in State2
        {4'd3,  1'b1, 1'b0, 3'd1, 3'd0, 3'b001, 2'd1, 1'b0},
        {4'd11, 1'b1, 1'b0, 3'd1, 3'd0, 3'b111, 2'd1, 1'b0},
        {4'd2,  1'b0, 1'b0, 3'd1, 3'd0, 3'b000, 2'd0, 1'b0}
    };

    task automatic check(input int req, input logic [2:0] act, input logic [2:0] exp,
                         input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s actual={state,trig}=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic step(input logic a, input logic r, input logic [2:0] c1,
                        input logic [2:0] c2, input logic [2:0] m);
        @(negedge clk);
        arm = a; ren = r; s1 = c1; s2 = c2; mt = m;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1 check(1, {st, trg}, 3'b000, "in reset");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 check(1, {st, trg}, 3'b000, "after reset");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8:6], VEC[i][5:3]);
            check(int'(VEC[i][17:14]), {st, trg}, VEC[i][2:0], $sformatf("vector %0d", i));
        end

        // R10 long hold in Final with strobes
        step(1'b1, 1'b0, 3'd5, 3'd0, 3'b001);
        check(6, {st, trg}, 3'b101, "any-event entry");
        for (int k = 0; k < 16; k++) begin
            step(1'b1, 1'b0, 3'd5, 3'd0, 3'(k % 8));
            check(10, {st, trg}, 3'b100, "final held");
        end
        step(1'b0, 1'b0, 3'd5, 3'd0, 3'b000);
        check(2, {st, trg}, 3'b000, "rearm path");

        // R1 asynchronous reset mid-sequence
        step(1'b1, 1'b0, 3'd1, 3'd3, 3'b001);
        check(3, {st, trg}, 3'b010, "into State2");
        @(negedge clk);
        mt = 3'b000;
        rst_n = 1'b0;
        #1 check(1, {st, trg}, 3'b000, "async reset");
        @(negedge clk) rst_n = 1'b1;
        step(1'b1, 1'b0, 3'd1, 3'd3, 3'b100);
        check(3, {st, trg}, 3'b000, "M2 ignored in State1 after reset");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R0 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule